// File: doc/BRIEF.md
# Guarded Halfword Multiply-Subtract Unit

This unit takes one 16-bit halfword from each of two 64-bit source operands, multiplies them, and subtracts the product from a 64-bit running accumulator. A three-bit operation select picks the halfword lane, signed or unsigned extension, and integer or fractional scaling. Each accepted operation writes the new 64-bit difference to a registered result, split into a high and a low 32-bit word. The same value is written back into the accumulator, so a chain of operations forms a multiply-subtract reduction.

In fractional mode the product is doubled. The resulting 33-bit quantity is sign-extended from its bit 32 before the subtraction, which guards the upper accumulator bits. All arithmetic wraps modulo 2^64. The unit reports no overflow and does not saturate. Results appear one clock after the operation is presented.

Top module: `hms_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the accumulator, the result and `out_valid` all become zero on that edge.
- R2: When `op_sel[0]` = 0 (low lane), the multiplier operands are bits [15:0] of each source. Bits [63:16] of both sources have no effect on the result.
- R3: When `op_sel[0]` = 1 (high lane), the multiplier operands are bits [31:16] of each source. Bits [63:32] and [15:0] have no effect on the result.
- R4: When `op_sel[2]` = 0 and `op_sel[1]` = 1 (signed integer), both halfwords are sign-extended and their full signed product is subtracted from the accumulator.
- R5: When `op_sel[2]` = 0 and `op_sel[1]` = 0 (unsigned integer), both halfwords are zero-extended and their full unsigned product is subtracted.
- R6: When `op_sel[2]` = 1 (fractional), the halfwords are treated as signed whatever `op_sel[1]` holds. The subtracted value is twice the signed product, sign-extended from bit 32, and its bit 0 is zero.
- R7: The new accumulator equals the old accumulator minus the product, modulo 2^64, with no saturation.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result's upper 32 bits appear on `result_hi` and its lower 32 bits on `result_lo`.
- R9: When `in_valid` is low, the accumulator and the result hold their values.
- R10: `{result_hi, result_lo}` always equals `acc_out`, both after an operation and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | [2] fractional, [1] signed, [0] high lane |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result produced by the previous cycle's operation |
| result_hi | output | 32 | Upper word of the difference |
| result_lo | output | 32 | Lower word of the difference |
| acc_out | output | 64 | Current accumulator value |

## Verification
The bench builds the unit with its default parameters: 16-bit halfwords and a 64-bit accumulator. These values bring the extreme operand pairs within reach: -32768 times -32768 in fractional mode, which sets bit 31 but not bit 32 of the doubled product, and 0xFFFF squared in unsigned mode. Subtracting from a zero accumulator wraps through 2^64 within a few operations. Random strobes with idle gaps and garbage in the unused source bits exercise the lane selection and the hold behaviour.

// File: rtl/hms_pkg.sv
// Package: shared operation encoding for the halfword multiply-subtract unit.
// Assumes the operation select is exactly three bits wide.
package hms_pkg;

    // Which halfword of the low source word feeds the multiplier.
    typedef enum logic {
        LANE_LOW  = 1'b0,
        LANE_HIGH = 1'b1
    } lane_e;

    // Packed so it overlays the op_sel port: [2] frac, [1] sgn, [0] lane.
    typedef struct packed {
        logic  frac;
        logic  sgn;
        lane_e lane;
    } op_t;

endpackage

// File: rtl/hms_lane_pick.sv
// Module: hms_lane_pick
// Selects one halfword from a word and extends it to word width.
// Assumes WORD_W is twice HALF_W; pure combinational.
module hms_lane_pick
    import hms_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  lane_e             lane,
    input  logic              sign_ext,
    output logic [WORD_W-1:0] ext_out
);

    logic [HALF_W-1:0] half_sel;

    // Pick the requested halfword.
    always_comb begin
        if (lane == LANE_HIGH) half_sel = word_in[WORD_W-1:HALF_W];
        else                   half_sel = word_in[HALF_W-1:0];
    end

    // Extend by sign or by zero.
    always_comb begin
        ext_out = {{HALF_W{sign_ext & half_sel[HALF_W-1]}}, half_sel};
    end

endmodule

// File: rtl/hms_product.sv
// Module: hms_product
// Forms the accumulator-width product of two extended halfwords.
// Integer mode gives the plain product; fractional mode doubles it and
// sign-extends from the guard bit just above the word. Assumes the inputs
// are already extended correctly for the mode, so the product fits the word.
module hms_product #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64,
    localparam int WORD_W = 2 * HALF_W,
    localparam int GUARD_W = WORD_W + 1
) (
    input  logic [WORD_W-1:0] ext_a,
    input  logic [WORD_W-1:0] ext_b,
    input  logic              frac,
    output logic [ACC_W-1:0]  prod
);

    logic signed [ACC_W-1:0] wide_a;
    logic signed [ACC_W-1:0] wide_b;
    logic signed [ACC_W-1:0] int_prod;
    logic [GUARD_W-1:0]      dbl_prod;

    // Widen operands; bit WORD_W-1 already holds sign or zero.
    always_comb begin
        wide_a = {{(ACC_W-WORD_W){ext_a[WORD_W-1]}}, ext_a};
        wide_b = {{(ACC_W-WORD_W){ext_b[WORD_W-1]}}, ext_b};
    end

    // Full integer product at accumulator width.
    always_comb begin
        int_prod = wide_a * wide_b;
    end

    // Doubled product kept to word width plus one guard bit.
    always_comb begin
        dbl_prod = {int_prod[WORD_W-1:0], 1'b0};
    end

    // Choose the mode; fractional result is sign-extended from the guard bit.
    always_comb begin
        if (frac) prod = {{(ACC_W-GUARD_W){dbl_prod[GUARD_W-1]}}, dbl_prod};
        else      prod = int_prod;
    end

endmodule

// File: rtl/hms_accum.sv
// Module: hms_accum
// Holds the accumulator and the registered result. On a strobe both take
// accumulator minus product, wrapping modulo 2^ACC_W. Synchronous active-low reset.
module hms_accum #(
    parameter int ACC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] res_q,
    output logic             vld_q
);

    logic [ACC_W-1:0] diff;

    // Wrapping difference.
    always_comb begin
        diff = acc_q - prod;
    end

    // Accumulator and result update on strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (in_valid) begin
            acc_q <= diff;
            res_q <= diff;
        end
    end

    // Result-valid follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= in_valid;
    end

endmodule

// File: rtl/hms_unit.sv
// Module: hms_unit (top)
// Guarded halfword multiply-subtract: picks a halfword from the low word of
// each source, multiplies (integer or doubled fractional), and subtracts the
// product from a 64-bit accumulator. One cycle latency; no saturation.
// Fractional mode always extends by sign.
module hms_unit
    import hms_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int SRC_W  = 64,
    parameter int ACC_W  = 64,
    localparam int WORD_W = 2 * HALF_W,
    localparam int N_SRC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [SRC_W-1:0]  src_a,
    input  logic [SRC_W-1:0]  src_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result_hi,
    output logic [WORD_W-1:0] result_lo,
    output logic [ACC_W-1:0]  acc_out
);

    op_t               op;
    logic              ext_signed;
    logic [SRC_W-1:0]  src_arr [N_SRC];
    logic [WORD_W-1:0] ext_arr [N_SRC];
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  res_q;

    // Decode the select; fractional forces sign extension.
    always_comb begin
        op         = op_t'(op_sel);
        ext_signed = op.sgn | op.frac;
        src_arr[0] = src_a;
        src_arr[1] = src_b;
    end

    // One lane picker per source operand.
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_pick
        hms_lane_pick #(.HALF_W(HALF_W)) i_pick (
            .word_in  (src_arr[gi][WORD_W-1:0]),
            .lane     (op.lane),
            .sign_ext (ext_signed),
            .ext_out  (ext_arr[gi])
        );
    end

    hms_product #(.HALF_W(HALF_W), .ACC_W(ACC_W)) i_prod (
        .ext_a (ext_arr[0]),
        .ext_b (ext_arr[1]),
        .frac  (op.frac),
        .prod  (prod)
    );

    hms_accum #(.ACC_W(ACC_W)) i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .prod     (prod),
        .acc_q    (acc_out),
        .res_q    (res_q),
        .vld_q    (out_valid)
    );

    // Split the registered result into destination words.
    always_comb begin
        result_hi = res_q[ACC_W-1 -: WORD_W];
        result_lo = res_q[WORD_W-1:0];
    end

endmodule

// File: rtl/hms_unit_chk.sv
// Module: hms_unit_chk
// Temporal checks for hms_unit, attached by bind below.
module hms_unit_chk #(
    parameter int ACC_W  = 64,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic [ACC_W-1:0]  prod,
    input logic              out_valid,
    input logic [WORD_W-1:0] result_hi,
    input logic [WORD_W-1:0] result_lo,
    input logic [ACC_W-1:0]  acc_out
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0) && !out_valid);

    assert_frac_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[2]) |->
            (prod[0] == 1'b0) && (prod[ACC_W-1:WORD_W+1] == {(ACC_W-WORD_W-1){prod[WORD_W]}}));

    assert_wrap_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid) |=> acc_out == $past(acc_out) - $past(prod));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> out_valid == $past(in_valid));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> $stable(acc_out));

    assert_result_matches_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> {result_hi, result_lo} == acc_out);

endmodule

bind hms_unit hms_unit_chk #(.ACC_W(ACC_W), .WORD_W(WORD_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .prod      (prod),
    .out_valid (out_valid),
    .result_hi (result_hi),
    .result_lo (result_lo),
    .acc_out   (acc_out)
);

// File: tb/test_hms_unit.sv
module test_hms_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [31:0] result_hi;
    logic [31:0] result_lo;
    logic [63:0] acc_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R7";

    // Reference model state
    logic [63:0] m_acc = '0;
    logic        m_vld = 1'b0;
    bit          done  = 1'b0;

    hms_unit i_hms_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .result_hi(result_hi), .result_lo(result_lo), .acc_out(acc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural product per the requirements.
    function automatic longint ref_prod(logic [2:0] op, logic [63:0] a, logic [63:0] b);
        logic [15:0] ha, hb;
        longint      x, y;
        ha = op[0] ? a[31:16] : a[15:0];
        hb = op[0] ? b[31:16] : b[15:0];
        if (op[2] || op[1]) begin
            x = longint'(signed'(ha));
            y = longint'(signed'(hb));
        end else begin
            x = longint'({48'd0, ha});
            y = longint'({48'd0, hb});
        end
        if (op[2]) return 2 * x * y;
        return x * y;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0;
            m_vld = 1'b0;
        end else begin
            if (in_valid) m_acc = m_acc - 64'(ref_prod(op_sel, src_a, src_b));
            m_vld = in_valid;
        end
    end

    // Compare on every falling edge while out of reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " acc"}, acc_out, m_acc);
            check("R8 out_valid", {63'd0, out_valid}, {63'd0, m_vld});
            check("R10 result", {result_hi, result_lo}, m_acc);
        end
    end

    task automatic op(string req, bit v, logic [2:0] s, logic [63:0] a, logic [63:0] b);
        @(negedge clk);
        cur_req  = req;
        in_valid = v;
        op_sel   = s;
        src_a    = a;
        src_b    = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 acc", acc_out, 64'd0);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", {result_hi, result_lo}, 64'd0);
        rst_n = 1'b1;
        // R2 low lane, garbage above bit 15
        op("R2", 1, 3'b010, 64'hDEAD_BEEF_1234_0003, 64'hCAFE_F00D_5678_0005);
        // R3 high lane, garbage elsewhere
        op("R3", 1, 3'b011, 64'hFFFF_FFFF_0007_ABCD, 64'h1111_2222_FFFE_9999);
        // R4 signed integer extremes
        op("R4", 1, 3'b010, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_FFFF);
        op("R4", 1, 3'b011, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
        // R5 unsigned integer max
        op("R5", 1, 3'b000, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF);
        op("R5", 1, 3'b001, 64'h0000_0000_FFFF_0000, 64'h0000_0000_8000_0000);
        // R6 fractional, signed bit clear and set
        op("R6", 1, 3'b100, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000);
        op("R6", 1, 3'b111, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_0000);
        op("R6", 1, 3'b101, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0001_0000);
        // R9 idle cycles with changing inputs
        op("R9", 0, 3'b000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        op("R9", 0, 3'b101, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        // R7 wrap: reset then subtract a positive product from zero
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        op("R7", 1, 3'b010, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0003);
        op("R7", 1, 3'b000, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF);
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            op("R7", ($urandom % 4) != 0, 3'($urandom),
               {$urandom, $urandom}, {$urandom, $urandom});
        end
        op("R9", 0, 3'b000, '0, '0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        done = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule